// File: doc/BRIEF.md
# Parallel Quadratic-Permutation Interleaver Address Generator

This block produces eight interleaved memory addresses per clock for a turbo decoder whose code block of size K is cut into eight equal sub-blocks, one per soft-decoding lane. Lane i walks the positions x = i·K/8 … (i+1)·K/8 − 1 and emits the permuted address A(x) = (f1·x + f2·x²) mod K for each one. The quadratic is never evaluated directly. Each lane keeps an address and an increment and steps both with two coupled first-order recursions: A(x+1) = (A(x) + g(x)) mod K and g(x+1) = (g(x) + 2·f2) mod K. Each modulo is a single add followed by a conditional subtraction of K.

The block is used in four steps. A configuration pulse sets K, f1 and f2. Lane 0 then starts at x = 0 by itself. The start address and start increment of every other lane come from an external table through a lane load port. A start pulse begins a run. From then on every cycle in which the consumer asserts advance while the addresses are valid moves all eight lanes one position forward in lockstep. After K/8 accepted advances the run ends and a done flag stays up until the next start.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` and `done` are both 0.
- R2: A `cfgLoad` pulse while no run is active stores K, f1 and f2, and sets lane 0's start point to address 0 with increment (f1 + f2) mod K. All three values must be below K, and K must be a multiple of 8 and at least 8.
- R3: A `laneLoad` pulse while no run is active stores `laneAddr` and `laneInc` as the start address and start increment of lane `laneSel`. Other lanes are unchanged.
- R4: A `start` pulse while no run is active raises `outValid` in the next cycle. Lane i's address, on bits [i·13 +: 13] of `outAddr`, then equals that lane's stored start address.
- R5: Each cycle with `outValid` and `advance` both high steps every lane. Its address becomes (A + g) mod K and its increment becomes (g + 2·f2) mod K. A lane started from position x therefore shows A(x + t) after t accepted advances.
- R6: While `outValid` is high and `advance` is low, `outAddr` and `outValid` keep their values into the next cycle.
- R7: The K/8-th accepted advance of a run clears `outValid` and sets `done` in the next cycle. `done` stays high until a start is accepted, and `outValid` and `done` are never high together.
- R8: `cfgLoad`, `laneLoad` and `start` have no effect while `outValid` is high. The running address sequence continues unchanged.
- R9: Every address shown while `outValid` is high is below K.
- R10: A start after a finished run replays the same address sequence from the stored start points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Store block size and coefficients |
| cfgBlkSize | input | 13 | Block size K |
| cfgF1 | input | 13 | Linear coefficient f1 |
| cfgF2 | input | 13 | Quadratic coefficient f2 |
| laneLoad | input | 1 | Store one lane's start point |
| laneSel | input | 3 | Lane written by `laneLoad` |
| laneAddr | input | 13 | Start address for the selected lane |
| laneInc | input | 13 | Start increment for the selected lane |
| start | input | 1 | Begin a run from the stored start points |
| advance | input | 1 | Consumer takes the current addresses |
| outValid | output | 1 | Addresses on `outAddr` are valid |
| done | output | 1 | Last run has completed |
| outAddr | output | 104 | Eight packed addresses, lane i at [i·13 +: 13] |

## Verification
The generator is run with several coefficient sets: a 40-bit block, a 48-bit block, a 1024-bit block and the largest 6144-bit block. These show whether the conditional subtraction keeps every step correct at both small and large moduli, and at a size where sums approach twice K. Advance is stalled on a regular pattern, which separates correct holding from stepping on every clock. One run loads a lane from an arbitrary off-grid position, which shows that lanes really use their loaded start points. Loads and start pulses injected in the middle of a run, and a second run after done, tell ignored commands apart from accepted ones and check that the start state is kept.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

  // Strobes from the sequencer to the address datapath
  typedef struct packed {
    logic loadCfg;   // latch K, coefficients, lane 0 start point
    logic loadLane;  // latch one lane's start point
    logic restart;   // copy start points into the running lanes
    logic step;      // advance every lane by one position
  } qppCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } qppStateT;

endpackage

// File: rtl/qpp_mod_add.sv
// (a + b) mod k for a, b < k: one add, one conditional subtract.
module qpp_mod_add #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] k,
  output logic [W-1:0] sum
);
  logic [W:0] rawSum;
  logic [W:0] wrapSum;

  always_comb begin
    rawSum  = {1'b0, a} + {1'b0, b};
    wrapSum = rawSum - {1'b0, k};
    sum     = (rawSum >= {1'b0, k}) ? wrapSum[W-1:0] : rawSum[W-1:0];
  end
endmodule

// File: rtl/qpp_ctrl.sv
// Run sequencer: gates commands, counts accepted advances per run.
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic          laneLoad,
  input  logic          start,
  input  logic          advance,
  input  logic [AW-1:0] blkSize,
  output qppCtrlT       ctrl,
  output logic          outValid,
  output logic          done
);
  localparam int LANE_SH = $clog2(LANES);

  qppStateT      state;
  logic [AW-1:0] stepCnt;
  logic [AW-1:0] laneLen;
  logic          running;
  logic          lastStep;

  always_comb begin
    running      = (state == ST_RUN);
    laneLen      = blkSize >> LANE_SH;
    lastStep     = (stepCnt == laneLen - AW'(1));
    ctrl.loadCfg  = cfgLoad  & ~running;
    ctrl.loadLane = laneLoad & ~running;
    ctrl.restart  = start    & ~running;
    ctrl.step     = advance  &  running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else if (ctrl.restart) begin
      state   <= ST_RUN;
      stepCnt <= '0;
    end else if (ctrl.step) begin
      if (lastStep) begin
        state   <= ST_FIN;
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + AW'(1);
      end
    end
  end

  assign outValid = (state == ST_RUN);
  assign done     = (state == ST_FIN);
endmodule

// File: rtl/qpp_datapath.sv
// Per-lane address/increment recursion with one shared step value.
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 13,
  parameter int LW    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  qppCtrlT             ctrl,
  input  logic [AW-1:0]       cfgBlkSize,
  input  logic [AW-1:0]       cfgF1,
  input  logic [AW-1:0]       cfgF2,
  input  logic [LW-1:0]       laneSel,
  input  logic [AW-1:0]       laneAddr,
  input  logic [AW-1:0]       laneInc,
  output logic [AW-1:0]       blkSize,
  output logic [LANES*AW-1:0] addrFlat
);
  logic [AW-1:0] blkSizeQ;
  logic [AW-1:0] twoF2Q;
  logic [AW-1:0] firstInc;
  logic [AW-1:0] twoF2New;

  // Config-time modular sums, evaluated against the incoming K
  qpp_mod_add #(.W(AW)) u_firstInc (
    .a(cfgF1), .b(cfgF2), .k(cfgBlkSize), .sum(firstInc)
  );
  qpp_mod_add #(.W(AW)) u_twoF2 (
    .a(cfgF2), .b(cfgF2), .k(cfgBlkSize), .sum(twoF2New)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkSizeQ <= '0;
      twoF2Q   <= '0;
    end else if (ctrl.loadCfg) begin
      blkSizeQ <= cfgBlkSize;
      twoF2Q   <= twoF2New;
    end
  end

  assign blkSize = blkSizeQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] startA;
    logic [AW-1:0] startG;
    logic [AW-1:0] curA;
    logic [AW-1:0] curG;
    logic [AW-1:0] nextA;
    logic [AW-1:0] nextG;
    logic          selHit;

    assign selHit = ctrl.loadLane && (laneSel == LW'(i));

    qpp_mod_add #(.W(AW)) u_addrStep (
      .a(curA), .b(curG), .k(blkSizeQ), .sum(nextA)
    );
    qpp_mod_add #(.W(AW)) u_incStep (
      .a(curG), .b(twoF2Q), .k(blkSizeQ), .sum(nextG)
    );

    // Stored start point; lane 0 also takes x = 0 from configuration
    if (i == 0) begin : g_origin
      always_ff @(posedge clk) begin
        if (!rstN) begin
          startA <= '0;
          startG <= '0;
        end else if (selHit) begin
          startA <= laneAddr;
          startG <= laneInc;
        end else if (ctrl.loadCfg) begin
          startA <= '0;
          startG <= firstInc;
        end
      end
    end else begin : g_table
      always_ff @(posedge clk) begin
        if (!rstN) begin
          startA <= '0;
          startG <= '0;
        end else if (selHit) begin
          startA <= laneAddr;
          startG <= laneInc;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        curA <= '0;
        curG <= '0;
      end else if (ctrl.restart) begin
        curA <= startA;
        curG <= startG;
      end else if (ctrl.step) begin
        curA <= nextA;
        curG <= nextG;
      end
    end

    assign addrFlat[i*AW +: AW] = curA;
  end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 13,
  parameter int LW    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [AW-1:0]       cfgBlkSize,
  input  logic [AW-1:0]       cfgF1,
  input  logic [AW-1:0]       cfgF2,
  input  logic                laneLoad,
  input  logic [LW-1:0]       laneSel,
  input  logic [AW-1:0]       laneAddr,
  input  logic [AW-1:0]       laneInc,
  input  logic                start,
  input  logic                advance,
  output logic                outValid,
  output logic                done,
  output logic [LANES*AW-1:0] outAddr
);
  qppCtrlT       ctrl;
  logic [AW-1:0] blkSizeQ;

  qpp_ctrl #(.LANES(LANES), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgLoad(cfgLoad), .laneLoad(laneLoad), .start(start), .advance(advance),
    .blkSize(blkSizeQ), .ctrl(ctrl), .outValid(outValid), .done(done)
  );

  qpp_datapath #(.LANES(LANES), .AW(AW), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .cfgBlkSize(cfgBlkSize), .cfgF1(cfgF1), .cfgF2(cfgF2),
    .laneSel(laneSel), .laneAddr(laneAddr), .laneInc(laneInc),
    .blkSize(blkSizeQ), .addrFlat(outAddr)
  );
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
  parameter int LANES = 8,
  parameter int AW    = 13
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                advance,
  input logic                outValid,
  input logic                done,
  input logic [AW-1:0]       blkSize,
  input logic [LANES*AW-1:0] outAddr
);
  function automatic logic allBelow(input logic [LANES*AW-1:0] v,
                                    input logic [AW-1:0] k);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (v[i*AW +: AW] >= k) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid, done}));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  assert_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> allBelow(outAddr, blkSize));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !advance |=> outValid && $stable(outAddr));

  assert_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && start |=> outValid);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && start && !advance |=> $stable(outAddr));
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .advance(advance),
  .outValid(outValid), .done(done), .blkSize(blkSizeQ), .outAddr(outAddr)
);

// File: tb/qpp_addr_gen_tb.sv
`timescale 1ns/1ps
module qpp_addr_gen_tb;
  localparam int LANES = 8;
  localparam int AW    = 13;
  localparam int LW    = 3;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cfgLoad = 1'b0;
  logic [AW-1:0]       cfgBlkSize = '0;
  logic [AW-1:0]       cfgF1 = '0;
  logic [AW-1:0]       cfgF2 = '0;
  logic                laneLoad = 1'b0;
  logic [LW-1:0]       laneSel = '0;
  logic [AW-1:0]       laneAddr = '0;
  logic [AW-1:0]       laneInc = '0;
  logic                start = 1'b0;
  logic                advance = 1'b0;
  logic                outValid;
  logic                done;
  logic [LANES*AW-1:0] outAddr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference model state
  bit      mRun = 0;
  bit      mDone = 0;
  longint  mT = 0;
  longint  mK = 8, mF1 = 0, mF2 = 0;
  longint  laneBase [LANES];

  always #5 clk = ~clk;

  qpp_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBlkSize(cfgBlkSize),
    .cfgF1(cfgF1), .cfgF2(cfgF2), .laneLoad(laneLoad), .laneSel(laneSel),
    .laneAddr(laneAddr), .laneInc(laneInc), .start(start), .advance(advance),
    .outValid(outValid), .done(done), .outAddr(outAddr)
  );

  function automatic longint polyAddr(longint k, longint f1, longint f2, longint x);
    return (f1 * x + f2 * x * x) % k;
  endfunction

  function automatic longint polyInc(longint k, longint f1, longint f2, longint x);
    return (f1 + f2 + 2 * f2 * x) % k;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare all outputs against the model (called at the falling edge)
  task automatic compareAll(input string tag);
    check(outValid == mRun, {tag, " R7 outValid"}, outValid, mRun);
    check(done == mDone, {tag, " R7 done"}, done, mDone);
    if (mRun) begin
      for (int i = 0; i < LANES; i++) begin
        longint got = longint'(outAddr[i*AW +: AW]);
        longint exp = polyAddr(mK, mF1, mF2, laneBase[i] + mT);
        check(got == exp, $sformatf("%s R5 lane%0d t=%0d", tag, i, mT), got, exp);
        check(got < mK, $sformatf("%s R9 lane%0d range", tag, i), got, mK - 1);
      end
    end
  endtask

  // One clock: drive at falling edge, update model at rising edge, compare
  task automatic cyc(input bit cL, input longint cK, input longint cF1, input longint cF2,
                     input bit lL, input int sel, input longint x, input bit st,
                     input bit adv, input string tag);
    cfgLoad    = cL;
    cfgBlkSize = AW'(cK);
    cfgF1      = AW'(cF1);
    cfgF2      = AW'(cF2);
    laneLoad   = lL;
    laneSel    = LW'(sel);
    laneAddr   = AW'(polyAddr(mK, mF1, mF2, x));
    laneInc    = AW'(polyInc(mK, mF1, mF2, x));
    if (cL) begin
      laneAddr = AW'(polyAddr(cK, cF1, cF2, x));
      laneInc  = AW'(polyInc(cK, cF1, cF2, x));
    end
    start   = st;
    advance = adv;
    @(posedge clk);
    if (!mRun) begin
      if (cL) begin
        mK = cK; mF1 = cF1; mF2 = cF2; laneBase[0] = 0;
      end
      if (lL) laneBase[sel] = x;
      if (st) begin
        mRun = 1; mT = 0; mDone = 0;
      end
    end else if (adv) begin
      if (mT == mK / LANES - 1) begin
        mRun = 0; mDone = 1;
      end else begin
        mT++;
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Run to done, stalling advance every fourth cycle
  task automatic runToDone(input string tag);
    int n = 0;
    while (mRun) begin
      cyc(0, 0, 0, 0, 0, 0, 0, 0, (n % 4) != 2, tag);
      n++;
    end
  endtask

  task automatic setupBlock(input longint k, input longint f1, input longint f2,
                            input string tag);
    cyc(1, k, f1, f2, 0, 0, 0, 0, 0, {tag, " R2 cfg"});
    for (int i = 1; i < LANES; i++)
      cyc(0, 0, 0, 0, 1, i, i * (k / LANES), 0, 0, {tag, " R3 lane"});
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LANES; i++) laneBase[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 0, "R1 outValid in reset", outValid, 0);
    check(done == 0, "R1 done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && done == 0, "R1 after reset", {outValid, done}, 0);

    // K=40: basic run, lane 0 from config, stalls
    setupBlock(40, 3, 10, "K40");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "K40 R4 start");
    check(outAddr[AW-1:0] == 0, "R2 lane0 first address", outAddr[AW-1:0], 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "K40 R6 hold");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "K40 R5 step");
    // Commands during a run are ignored
    cyc(1, 48, 7, 12, 0, 0, 0, 0, 0, "K40 R8 cfg ignored");
    cyc(0, 0, 0, 0, 1, 2, 1, 0, 1, "K40 R8 lane ignored");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "K40 R8 start ignored");
    runToDone("K40 R5");
    idle("K40 R7 done held");
    idle("K40 R7 done held");

    // K=48: replay after done
    setupBlock(48, 7, 12, "K48");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "K48 R4 start");
    runToDone("K48 R5");
    idle("K48 R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "K48 R10 restart");
    runToDone("K48 R10 replay");

    // K=1024 with lane 3 loaded off-grid
    setupBlock(1024, 31, 64, "K1024");
    cyc(0, 0, 0, 0, 1, 3, 5, 0, 0, "K1024 R3 off-grid lane3");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "K1024 R4 start");
    runToDone("K1024 R5");

    // Largest block
    setupBlock(6144, 263, 480, "K6144");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "K6144 R4 start");
    runToDone("K6144 R5");
    idle("K6144 R7");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule